// File: doc/BRIEF.md
# Redirecting I/O Interrupt Router

This block gathers 24 interrupt input pins and turns each request into a delivery message on a valid/ready output. Each pin owns a 64-bit redirection entry. The entry sets the message fields (vector, delivery mode, destination mode, polarity, trigger kind and destination) and carries a per-pin mask. Pin levels are sampled on the clock. A per-pin request register applies edge or level semantics to the sampled level. Any new input event, and any write to a table entry, starts a scan. The scan walks the pins from index 0 upward and emits one message for each pending pin that is not masked.

Software reaches all state through two 32-bit words on a simple memory-mapped bus. One word is a select register, and the other is a data window onto the selected internal register. The internal registers are an identification register, a read-only version word, a reserved zero word, and the two halves of every redirection entry. Reads are combinational from the address. Writes take effect on the clock edge where enable and write are both high.

Top module: `intr_redirector`

## Requirements
- R1: After reset the select register and the ID read 0, no message is valid, and every entry reads 0x00010000 in its low half and 0 in its high half (only the mask bit, bit 16, set).
- R2: Byte offset 0x00 is the select register, read back in bits 7:0. Offset 0x10 is the data window. Every other offset reads 0, and writes to it change nothing.
- R3: Select value 0x00 is the ID register. It reads as ID<<24, and a write keeps only bits 31:24 of the data.
- R4: Select value 0x01 reads 0x00170011 (version 0x11, pin count minus one in bits 23:16). Select value 0x02 reads 0. Writes to both are ignored. Select values above 0x3F read 0.
- R5: Select value 0x10+2n is the low word of entry n, and 0x10+2n+1 is its high word. A write changes only the addressed word.
- R6: A message carries destination = entry[63:56], destination mode = entry[11], delivery mode = entry[10:8], vector = entry[7:0], polarity = entry[13] and trigger kind = entry[15] (1 = level).
- R7: An edge pin (entry bit 15 = 0) sets its request only on a 0-to-1 change of its sampled level. It is emitted once and its request is then cleared. Holding it high or driving it low gives no further message.
- R8: A level pin (entry bit 15 = 1) has its request set while its sampled level is high and cleared while it is low. Emitting it does not clear the request.
- R9: A pending pin whose mask bit (16) is set emits nothing but keeps its request. It is emitted once a table write clears its mask.
- R10: Within a scan, messages leave in ascending pin index order, at most one per cycle.
- R11: While the output is valid and not ready, the valid signal and every message field hold their values.
- R12: A write to any entry word starts a scan even when no input pin has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | Interrupt input levels |
| cfg_en | input | 1 | Bus access strobe |
| cfg_we | input | 1 | Bus write when high, read when low |
| cfg_addr | input | 8 | Bus byte offset |
| cfg_wdata | input | 32 | Bus write data |
| cfg_rdata | output | 32 | Bus read data (combinational) |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_logical | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Pin polarity bit |
| msg_level | output | 1 | Trigger kind, 1 = level |

## Verification
The assertions check four properties on every cycle: the message stays steady under back-pressure, the scan index advances by at most one inside a pass, a capture never picks a masked pin, and a service clear touches at most one pin and never a level pin. Several behaviours can only be shown by the bench scenarios. These are the register map read-back, the exact field mapping into messages, the single message per edge, the repeated messages for a level pin held high, and the release of a masked request once it is unmasked.

// File: rtl/intr_redir_pkg.sv
package intr_redir_pkg;

  localparam int ENTRY_W = 64;
  localparam int WORD_W  = 32;

  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  localparam logic [7:0] VERSION_CODE = 8'h11;
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_TABLE    = 8'h10;
  localparam logic [7:0] OFF_SELECT   = 8'h00;
  localparam logic [7:0] OFF_WINDOW   = 8'h10;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_logical;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
    logic       polarity;
    logic       level;
  } redir_msg_t;

  function automatic redir_msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    redir_msg_t m;
    m.dest         = e[DEST_LSB +: 8];
    m.dest_logical = e[DMODE_BIT];
    m.dlv_mode     = e[DLV_LSB +: 3];
    m.vector       = e[VEC_LSB +: 8];
    m.polarity     = e[POL_BIT];
    m.level        = e[TRIG_BIT];
    return m;
  endfunction

  function automatic logic entry_masked(input logic [ENTRY_W-1:0] e);
    return e[MASK_BIT];
  endfunction

  function automatic logic entry_level(input logic [ENTRY_W-1:0] e);
    return e[TRIG_BIT];
  endfunction

  function automatic logic [ENTRY_W-1:0] entry_reset_value();
    return ENTRY_W'(1) << MASK_BIT;
  endfunction

  function automatic logic [WORD_W-1:0] version_word(input int pins);
    return {8'h00, 8'(pins - 1), 8'h00, VERSION_CODE};
  endfunction

  // Next request state of one pin from trigger kind, sampled level,
  // sampled rising transition, service clear and current state.
  function automatic logic next_request(input logic lvl, input logic sampled,
                                        input logic rose, input logic clr,
                                        input logic cur);
    if (lvl)       return sampled;
    else if (rose) return 1'b1;
    else if (clr)  return 1'b0;
    else           return cur;
  endfunction

endpackage

// File: rtl/intr_redir_regs.sv
module intr_redir_regs
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  output logic [ENTRY_W-1:0] entry_q [NUM_PINS],
  output logic [NUM_PINS-1:0] mask_vec,
  output logic [NUM_PINS-1:0] level_vec,
  output logic               table_wr
);

  localparam int TABLE_END = int'(SEL_TABLE) + 2 * NUM_PINS;

  logic [7:0]       sel_q;
  logic [7:0]       id_q;
  logic             at_select, at_window;
  logic             wr_select, wr_window;
  logic             tbl_hit, tbl_hi;
  logic [7:0]       tbl_off;
  logic [PIN_W-1:0] tbl_pin;

  assign at_select = (cfg_addr == ADDR_W'(OFF_SELECT));
  assign at_window = (cfg_addr == ADDR_W'(OFF_WINDOW));
  assign wr_select = cfg_en && cfg_we && at_select;
  assign wr_window = cfg_en && cfg_we && at_window;

  assign tbl_off = sel_q - SEL_TABLE;
  assign tbl_hit = (sel_q >= SEL_TABLE) && (int'(sel_q) < TABLE_END);
  assign tbl_pin = PIN_W'(tbl_off >> 1);
  assign tbl_hi  = tbl_off[0];
  assign table_wr = wr_window && tbl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_select) sel_q <= cfg_wdata[7:0];
      if (wr_window && sel_q == SEL_ID) id_q <= cfg_wdata[31:24];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[p] <= entry_reset_value();
      end else if (table_wr && tbl_pin == PIN_W'(p)) begin
        if (tbl_hi) entry_q[p][63:32] <= cfg_wdata;
        else        entry_q[p][31:0]  <= cfg_wdata;
      end
    end
    assign mask_vec[p]  = entry_masked(entry_q[p]);
    assign level_vec[p] = entry_level(entry_q[p]);
  end

  always_comb begin
    cfg_rdata = '0;
    if (at_select) begin
      cfg_rdata = {24'h0, sel_q};
    end else if (at_window) begin
      if (sel_q == SEL_ID)       cfg_rdata = {id_q, 24'h0};
      else if (sel_q == SEL_VER) cfg_rdata = version_word(NUM_PINS);
      else if (tbl_hit)          cfg_rdata = tbl_hi ? entry_q[tbl_pin][63:32]
                                                    : entry_q[tbl_pin][31:0];
    end
  end

endmodule

// File: rtl/intr_redir_req.sv
module intr_redir_req
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] req_vec,
  output logic                pin_event
);

  logic [NUM_PINS-1:0] pin_s, pin_d, rose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s <= '0;
      pin_d <= '0;
    end else begin
      pin_s <= pin_in;
      pin_d <= pin_s;
    end
  end

  assign rose      = pin_s & ~pin_d;
  assign pin_event = |rose;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_vec[p] <= 1'b0;
      else        req_vec[p] <= next_request(level_vec[p], pin_s[p], rose[p],
                                             clr_vec[p], req_vec[p]);
    end
  end

endmodule

// File: rtl/intr_redir_scan.sv
module intr_redir_scan
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trigger,
  input  logic [NUM_PINS-1:0] req_vec,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic [ENTRY_W-1:0]  entry_q [NUM_PINS],
  output logic                msg_valid,
  input  logic                msg_ready,
  output redir_msg_t          msg_q,
  output logic [NUM_PINS-1:0] clr_vec,
  output logic                scan_active,
  output logic [PIN_W-1:0]    scan_idx,
  output logic                scan_wrap,
  output logic                cap_fire
);

  logic rerun_q, advance, last_pin, eligible;

  assign last_pin = (scan_idx == PIN_W'(NUM_PINS - 1));
  assign advance  = scan_active && (!msg_valid || msg_ready);
  assign eligible = req_vec[scan_idx] && !mask_vec[scan_idx];
  assign cap_fire = advance && eligible;
  assign scan_wrap = advance && last_pin;

  always_comb begin
    clr_vec = '0;
    if (cap_fire && !level_vec[scan_idx]) clr_vec[scan_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_q       <= '0;
      scan_idx    <= '0;
      scan_active <= 1'b0;
      rerun_q     <= 1'b0;
    end else begin
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (cap_fire) begin
        msg_valid <= 1'b1;
        msg_q     <= entry_to_msg(entry_q[scan_idx]);
      end
      if (advance) scan_idx <= last_pin ? '0 : scan_idx + 1'b1;
      if (!scan_active) begin
        if (trigger) scan_active <= 1'b1;
      end else if (scan_wrap) begin
        if (rerun_q || trigger) rerun_q <= 1'b0;
        else                    scan_active <= 1'b0;
      end else if (trigger) begin
        rerun_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/intr_redirector.sv
module intr_redirector
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_en,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_logical,
  output logic [2:0]          msg_dlv_mode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_level
);

  logic [ENTRY_W-1:0]  entry_q [NUM_PINS];
  logic [NUM_PINS-1:0] mask_vec, level_vec, req_vec, clr_vec;
  logic                table_wr, pin_event, scan_trigger;
  logic                scan_active, scan_wrap, cap_fire;
  logic [PIN_W-1:0]    scan_idx;
  redir_msg_t          msg_q;

  intr_redir_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .entry_q(entry_q), .mask_vec(mask_vec), .level_vec(level_vec),
    .table_wr(table_wr)
  );

  intr_redir_req #(.NUM_PINS(NUM_PINS)) req_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level_vec(level_vec),
    .clr_vec(clr_vec), .req_vec(req_vec), .pin_event(pin_event)
  );

  assign scan_trigger = pin_event || table_wr;

  intr_redir_scan #(.NUM_PINS(NUM_PINS)) scan_i (
    .clk(clk), .rst_n(rst_n), .trigger(scan_trigger), .req_vec(req_vec),
    .mask_vec(mask_vec), .level_vec(level_vec), .entry_q(entry_q),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_q(msg_q),
    .clr_vec(clr_vec), .scan_active(scan_active), .scan_idx(scan_idx),
    .scan_wrap(scan_wrap), .cap_fire(cap_fire)
  );

  assign msg_dest         = msg_q.dest;
  assign msg_dest_logical = msg_q.dest_logical;
  assign msg_dlv_mode     = msg_q.dlv_mode;
  assign msg_vector       = msg_q.vector;
  assign msg_polarity     = msg_q.polarity;
  assign msg_level        = msg_q.level;

endmodule

// File: rtl/intr_redirector_chk.sv
module intr_redirector_chk
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS),
  localparam int MSG_W   = $bits(redir_msg_t)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [MSG_W-1:0]    msg_bits,
  input logic                scan_active,
  input logic [PIN_W-1:0]    scan_idx,
  input logic                scan_wrap,
  input logic                cap_fire,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] level_vec
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_bits)));

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && $past(scan_active) && !$past(scan_wrap))
      |-> (PIN_W'(scan_idx - $past(scan_idx)) <= PIN_W'(1)));

  assert_capture_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> msg_valid);

  assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  assert_level_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & level_vec) == '0);

  assert_masked_skipped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> !mask_vec[scan_idx]);

endmodule

bind intr_redirector intr_redirector_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_bits(msg_q), .scan_active(scan_active), .scan_idx(scan_idx),
  .scan_wrap(scan_wrap), .cap_fire(cap_fire), .clr_vec(clr_vec),
  .mask_vec(mask_vec), .level_vec(level_vec)
);

// File: tb/intr_redirector_tb_top.sv
module intr_redirector_tb_top;

  localparam int PINS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [PINS-1:0] pin_in = '0;
  logic        cfg_en = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_dest, msg_vector;
  logic        msg_dest_logical, msg_polarity, msg_level;
  logic [2:0]  msg_dlv_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rec_cnt = 0;
  logic [21:0] rec [64];

  always #4 clk = ~clk;

  intr_redirector dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_logical(msg_dest_logical), .msg_dlv_mode(msg_dlv_mode),
    .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_level(msg_level)
  );

  function automatic logic [21:0] out_word();
    return {msg_dest, msg_dest_logical, msg_dlv_mode, msg_vector, msg_polarity, msg_level};
  endfunction

  // Expected message built from the entry words as the requirement lists the fields.
  function automatic logic [21:0] expect_msg(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[31:24], lo[11], lo[10:8], lo[7:0], lo[13], lo[15]};
  endfunction

  always @(negedge clk) begin
    #2;
    if (msg_valid && msg_ready && rec_cnt < 64) begin
      rec[rec_cnt] = out_word();
      rec_cnt = rec_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_en = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 0; cfg_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_en = 1; cfg_we = 0; cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_en = 0;
  endtask

  task automatic win_write(input logic [7:0] sel, input logic [31:0] d);
    bus_write(8'h00, {24'h0, sel});
    bus_write(8'h10, d);
  endtask

  task automatic win_read(input logic [7:0] sel, output logic [31:0] d);
    bus_write(8'h00, {24'h0, sel});
    bus_read(8'h10, d);
  endtask

  task automatic set_entry(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    win_write(8'(8'h10 + 2 * pin + 1), hi);
    win_write(8'(8'h10 + 2 * pin), lo);
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 valid", {31'h0, msg_valid}, 32'h0);
    bus_read(8'h00, d); check("R1 select", d, 32'h0);
    for (int p = 0; p < PINS; p++) begin
      win_read(8'(8'h10 + 2 * p), d);     check("R1 entry low", d, 32'h0001_0000);
      win_read(8'(8'h10 + 2 * p + 1), d); check("R1 entry high", d, 32'h0);
    end
    win_read(8'h00, d); check("R1 id", d, 32'h0);
  endtask

  task automatic t_offsets();
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_002A);
    bus_read(8'h00, d); check("R2 select readback", d, 32'h2A);
    bus_write(8'h20, 32'h0000_0013);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h20, d); check("R2 other offset reads 0", d, 32'h0);
    bus_read(8'h04, d); check("R2 other offset reads 0", d, 32'h0);
    bus_read(8'h00, d); check("R2 select untouched", d, 32'h2A);
  endtask

  task automatic t_id();
    logic [31:0] d;
    win_write(8'h00, 32'hA512_3456);
    win_read(8'h00, d); check("R3 id", d, 32'hA500_0000);
  endtask

  task automatic t_version();
    logic [31:0] d;
    win_read(8'h01, d); check("R4 version", d, 32'h0017_0011);
    win_write(8'h01, 32'hFFFF_FFFF);
    win_read(8'h01, d); check("R4 version after write", d, 32'h0017_0011);
    win_write(8'h02, 32'hFFFF_FFFF);
    win_read(8'h02, d); check("R4 reserved word", d, 32'h0);
    win_write(8'h40, 32'h1234_5678);
    win_read(8'h40, d); check("R4 beyond table", d, 32'h0);
    win_read(8'h3F, d); check("R4 last entry high untouched", d, 32'h0);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    win_write(8'h1A, 32'h0001_0A33);
    win_write(8'h1B, 32'hC100_0000);
    win_read(8'h1A, d); check("R5 low word", d, 32'h0001_0A33);
    win_read(8'h1B, d); check("R5 high word", d, 32'hC100_0000);
    win_write(8'h1A, 32'h0001_00EE);
    win_read(8'h1B, d); check("R5 high kept", d, 32'hC100_0000);
    win_read(8'h1A, d); check("R5 low updated", d, 32'h0001_00EE);
    check("R5 no message from masked entry", rec_cnt, 0);
  endtask

  task automatic t_edge();
    rec_cnt = 0;
    set_entry(3, 32'h0000_2A43, 32'h9C00_0000);
    settle();
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    check("R7 one message", rec_cnt, 1);
    check("R6 fields", {10'h0, rec[0]}, {10'h0, expect_msg(32'h2A43, 32'h9C00_0000)});
    rec_cnt = 0;
    win_write(8'h17, 32'h9C00_0000);
    settle();
    check("R7 request cleared after service", rec_cnt, 0);
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    win_write(8'h17, 32'h9C00_0000);
    settle();
    check("R7 low has no effect", rec_cnt, 0);
  endtask

  task automatic t_level();
    rec_cnt = 0;
    set_entry(7, 32'h0000_8557, 32'h1100_0000);
    settle();
    @(negedge clk); pin_in[7] = 1'b1;
    settle();
    check("R8 level message", rec_cnt, 1);
    check("R6 level fields", {10'h0, rec[0]}, {10'h0, expect_msg(32'h8557, 32'h1100_0000)});
    rec_cnt = 0;
    win_write(8'h1F, 32'h1100_0000);
    settle();
    check("R12 table write rescans, R8 request kept", rec_cnt, 1);
    rec_cnt = 0;
    @(negedge clk); pin_in[7] = 1'b0;
    settle();
    win_write(8'h1F, 32'h1100_0000);
    settle();
    check("R8 low clears request", rec_cnt, 0);
  endtask

  task automatic t_mask();
    rec_cnt = 0;
    set_entry(9, 32'h0001_0069, 32'h2200_0000);
    settle();
    @(negedge clk); pin_in[9] = 1'b1;
    settle();
    check("R9 masked no message", rec_cnt, 0);
    @(negedge clk); pin_in[9] = 1'b0;
    win_write(8'h22, 32'h0000_0069);
    settle();
    check("R9 unmask releases", rec_cnt, 1);
    check("R9 released vector", {24'h0, rec[0][9:2]}, 32'h69);
    rec_cnt = 0;
    win_write(8'h22, 32'h0000_0069);
    settle();
    check("R9 released once", rec_cnt, 0);
  endtask

  task automatic t_order();
    rec_cnt = 0;
    set_entry(2,  32'h0000_0062, 32'h0);
    set_entry(12, 32'h0000_0072, 32'h0);
    set_entry(20, 32'h0000_0080, 32'h0);
    settle();
    @(negedge clk); pin_in[20] = 1'b1; pin_in[2] = 1'b1; pin_in[12] = 1'b1;
    settle();
    check("R10 count", rec_cnt, 3);
    check("R10 first",  {24'h0, rec[0][9:2]}, 32'h62);
    check("R10 second", {24'h0, rec[1][9:2]}, 32'h72);
    check("R10 third",  {24'h0, rec[2][9:2]}, 32'h80);
    @(negedge clk); pin_in = '0;
    settle();
  endtask

  task automatic t_backpressure();
    logic [21:0] held;
    rec_cnt = 0;
    set_entry(15, 32'h0000_049F, 32'h3300_0000);
    settle();
    @(negedge clk); msg_ready = 1'b0; pin_in[15] = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    check("R11 valid held", {31'h0, msg_valid}, 32'h1);
    held = out_word();
    check("R11 held vector", {24'h0, msg_vector}, 32'h9F);
    repeat (10) @(negedge clk);
    #1;
    check("R11 still valid", {31'h0, msg_valid}, 32'h1);
    check("R11 fields stable", {10'h0, out_word()}, {10'h0, held});
    check("R11 nothing taken", rec_cnt, 0);
    @(negedge clk); msg_ready = 1'b1;
    settle();
    check("R11 delivered once", rec_cnt, 1);
    check("R11 delivered fields", {10'h0, rec[0]},
          {10'h0, expect_msg(32'h049F, 32'h3300_0000)});
    @(negedge clk); pin_in[15] = 1'b0;
    settle();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_offsets();
    t_id();
    t_version();
    t_halves();
    t_edge();
    t_level();
    t_mask();
    t_order();
    t_backpressure();
    finish_run();
  end

endmodule